// File: doc/BRIEF.md
# Gated Fractional Tick Divider

This block turns a stream of input events into a single-cycle count-enable tick for a PWM counter. The divide ratio is an unsigned fixed-point number with an 8-bit integer part and a 4-bit fraction. A small accumulator adds the fraction once per output period. When the accumulator wraps past 16, the next period is lengthened by one input event. Over many periods the average ratio is therefore integer + fraction/16.

What counts as an input event depends on a 2-bit mode. In free-running mode every clock cycle is an event. In level mode a cycle is an event only while an external gate input is high. The two edge modes count each rising edge, or each falling edge, of that input as one event. The gate input is asynchronous, so it passes through a two-flop synchroniser before it is used for level gating or edge detection. Dropping the enable clears the divider at once.

Top module: `pwm_tick_divider`

## Requirements
- R1: While `rst_n` is low, `tick` is 0. After reset the divider starts a fresh period with a cleared accumulator.
- R2: With integer 1, fraction 0 and mode 0 (free-running), `tick` is high on every clock cycle while `enable` is high.
- R3: With fraction 0 and integer N (1..255), exactly one tick is produced per N input events. The tick is asserted in the cycle after the N-th event.
- R4: With fraction F, the accumulator adds F at the end of every period. The period after a carry out of the 4-bit accumulator lasts one extra event. Example: integer 2 with fraction 8 gives periods of 2,2,3,2,3,... events. Example: integer 3 with fraction 2 gives 32 ticks in the first 100 events.
- R5: An integer value of 0 gives a period of 256 events.
- R6: In mode 1, a clock cycle is an event only while the synchronised gate input is high. No tick follows a cycle in which it is low.
- R7: In mode 2, each rising edge of the synchronised gate input is one event. With integer 1, two ticks are never in adjacent cycles while the mode is held.
- R8: In mode 3, each falling edge of the synchronised gate input is one event.
- R9: The gate input passes through a two-flop synchroniser. With integer 1 in mode 2, a rising edge of `b_in` set up before a clock edge makes `tick` high after the third clock edge and low again after the fourth.
- R10: While `enable` is low, `tick` is 0 from the next clock edge. The event counter, accumulator and stretch flag are cleared, so a re-enable starts a full new period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Runs the divider; low clears it |
| div_int | input | INT_W | Integer part of the ratio, 0 means 256 |
| div_frac | input | FRAC_W | Fractional part of the ratio, in sixteenths |
| mode | input | 2 | 0 free-run, 1 gate-high level, 2 rising edge, 3 falling edge |
| b_in | input | 1 | Asynchronous gate / event input |
| tick | output | 1 | One-cycle count-enable pulse |

## Verification
Two functions can fall in the same cycle. The first pair is a period-ending input event and a drop of `enable`. The bench withdraws `enable` exactly when the fourth event of a divide-by-4 period arrives. It then expects no tick, and a full four-event period after re-enable. The second pair is the end of a period and a carry out of the fraction accumulator. The fractional runs set this up and are judged by tick counts over fixed event windows. A behavioural model, with its own synchroniser history, also checks `tick` on every clock.

// File: rtl/pwm_tick_divider.sv
module pwm_tick_divider #(
  parameter int INT_W  = 8,
  parameter int FRAC_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [INT_W-1:0]  div_int,
  input  logic [FRAC_W-1:0] div_frac,
  input  logic [1:0]        mode,
  input  logic              b_in,
  output logic              tick
);
  localparam int CNT_W = INT_W + 1;
  localparam logic [CNT_W:0] FULL = (CNT_W+1)'(1) << INT_W;
  localparam logic [1:0] M_FREE = 2'd0, M_LEVEL = 2'd1, M_RISE = 2'd2, M_FALL = 2'd3;

  logic b_s1, b_s2, b_d;
  logic evt;
  logic [CNT_W-1:0] cnt;
  logic [FRAC_W-1:0] acc;
  logic stretch;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) {b_s1, b_s2, b_d} <= '0;
    else        {b_s1, b_s2, b_d} <= {b_in, b_s1, b_s2};

  always_comb
    case (mode)
      M_FREE:  evt = 1'b1;
      M_LEVEL: evt = b_s2;
      M_RISE:  evt = b_s2 & ~b_d;
      M_FALL:  evt = ~b_s2 & b_d;
      default: evt = 1'b0;
    endcase

  wire [CNT_W:0]  period   = ((div_int == '0) ? FULL : {{(CNT_W+1-INT_W){1'b0}}, div_int})
                             + {{CNT_W{1'b0}}, stretch};
  wire [CNT_W:0]  next_cnt = {1'b0, cnt} + 1'b1;
  wire            done     = evt && (next_cnt >= period);
  wire [FRAC_W:0] acc_sum  = {1'b0, acc} + {1'b0, div_frac};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n || !enable) begin
      cnt <= '0; acc <= '0; stretch <= 1'b0; tick <= 1'b0;
    end else begin
      tick <= done;
      if (done) begin
        cnt     <= '0;
        acc     <= acc_sum[FRAC_W-1:0];
        stretch <= acc_sum[FRAC_W];
      end else if (evt) begin
        cnt <= next_cnt[CNT_W-1:0];
      end
    end

  a_r10_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !tick);

  a_r6_low_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_LEVEL && !b_s2) |=> !tick);

  a_r7_edge_spaced: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && $past(mode[1]) && $past(mode, 2) == $past(mode)) |-> !$past(tick));

  a_r5_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, cnt} <= FULL);
endmodule

// File: tb/test_pwm_tick_divider.sv
module test_pwm_tick_divider;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0, enable = 0, b_in = 0;
  logic [7:0] div_int = 8'd1;
  logic [3:0] div_frac = 4'd0;
  logic [1:0] mode = 2'd0;
  logic tick;

  int checks = 0, fails = 0, tick_cnt = 0;
  string cur_req = "R1";
  bit done = 0;

  pwm_tick_divider i_pwm_tick_divider (
    .clk(clk), .rst_n(rst_n), .enable(enable), .div_int(div_int),
    .div_frac(div_frac), .mode(mode), .b_in(b_in), .tick(tick));

  always #(CLK_PERIOD/2) clk = ~clk;

  int p1, p2, p3, m_cnt, m_acc, m_str, tgt;
  bit exp_tick, ev;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p1 = 0; p2 = 0; p3 = 0; m_cnt = 0; m_acc = 0; m_str = 0; exp_tick = 0;
    end else begin
      case (mode)
        2'd0: ev = 1;
        2'd1: ev = (p2 == 1);
        2'd2: ev = (p2 == 1 && p3 == 0);
        default: ev = (p2 == 0 && p3 == 1);
      endcase
      if (!enable) begin
        m_cnt = 0; m_acc = 0; m_str = 0; exp_tick = 0;
      end else if (ev) begin
        tgt = ((div_int == 0) ? 256 : int'(div_int)) + m_str;
        if (m_cnt + 1 >= tgt) begin
          exp_tick = 1; m_cnt = 0;
          m_acc = m_acc + int'(div_frac);
          m_str = (m_acc >= 16) ? 1 : 0;
          m_acc = m_acc % 16;
        end else begin
          exp_tick = 0; m_cnt = m_cnt + 1;
        end
      end else exp_tick = 0;
      p3 = p2; p2 = p1; p1 = int'(b_in);
    end
  end

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    check(cur_req, int'(tick), int'(exp_tick));
    if (tick) tick_cnt++;
  end

  task automatic cfg(input string req, input logic [1:0] md, input int iv, input int fv);
    @(negedge clk);
    enable = 0; mode = md; div_int = 8'(iv); div_frac = 4'(fv); cur_req = req;
    repeat (2) @(negedge clk);
  endtask

  task automatic run_count(input int k, input int exp, input string tag);
    enable = 1; tick_cnt = 0;
    repeat (k) @(negedge clk);
    #1;
    check(tag, tick_cnt, exp);
    enable = 0;
  endtask

  task automatic pulses(input int n, input int hi, input int lo);
    for (int i = 0; i < n; i++) begin
      b_in = 1; repeat (hi) @(negedge clk);
      b_in = 0; repeat (lo) @(negedge clk);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset", int'(tick), 0);
    rst_n = 1;
    @(negedge clk);

    cfg("R2", 2'd0, 1, 0);
    run_count(20, 20, "R2 free-run ticks");

    cfg("R3", 2'd0, 5, 0);
    run_count(40, 8, "R3 divide by 5");

    cfg("R4", 2'd0, 2, 8);
    run_count(54, 22, "R4 ratio 2.5");
    cfg("R4", 2'd0, 3, 2);
    run_count(100, 32, "R4 ratio 3+2/16");

    cfg("R5", 2'd0, 0, 0);
    run_count(600, 2, "R5 integer 0 as 256");

    cfg("R6", 2'd1, 2, 0);
    enable = 1; b_in = 0; repeat (4) @(negedge clk);
    tick_cnt = 0;
    b_in = 1; repeat (10) @(negedge clk);
    b_in = 0; repeat (6) @(negedge clk);
    #1; check("R6 level gate ticks", tick_cnt, 5);
    tick_cnt = 0; repeat (8) @(negedge clk);
    #1; check("R6 gate low no ticks", tick_cnt, 0);
    enable = 0;

    cfg("R7", 2'd2, 1, 0);
    enable = 1; repeat (4) @(negedge clk);
    tick_cnt = 0;
    pulses(5, 3, 3); repeat (6) @(negedge clk);
    #1; check("R7 rising edge ticks", tick_cnt, 5);
    enable = 0;

    cfg("R8", 2'd3, 1, 0);
    enable = 1; repeat (4) @(negedge clk);
    tick_cnt = 0;
    pulses(5, 2, 4); repeat (6) @(negedge clk);
    #1; check("R8 falling edge ticks", tick_cnt, 5);
    enable = 0;

    cfg("R8", 2'd3, 2, 0);
    enable = 1; repeat (4) @(negedge clk);
    tick_cnt = 0;
    pulses(6, 3, 3); repeat (6) @(negedge clk);
    #1; check("R8 falling edges divided by 2", tick_cnt, 3);
    enable = 0;

    cfg("R9", 2'd2, 1, 0);
    enable = 1; repeat (4) @(negedge clk);
    b_in = 1;
    @(negedge clk); check("R9 latency edge 1", int'(tick), 0);
    @(negedge clk); check("R9 latency edge 2", int'(tick), 0);
    @(negedge clk); check("R9 latency edge 3", int'(tick), 1);
    @(negedge clk); check("R9 latency edge 4", int'(tick), 0);
    b_in = 0; repeat (4) @(negedge clk);
    enable = 0;

    cfg("R10", 2'd0, 4, 0);
    enable = 1; repeat (3) @(negedge clk);
    enable = 0;
    @(negedge clk); check("R10 disable on period end", int'(tick), 0);
    enable = 1;
    repeat (3) @(negedge clk);
    check("R10 restart not early", int'(tick), 0);
    @(negedge clk); check("R10 full period after re-enable", int'(tick), 1);
    enable = 0;
    repeat (3) @(negedge clk);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule